// File: doc/BRIEF.md
# Interrupt status and mask unit

This block gathers single-cycle event pulses from the receive, transmit, link, FIFO and bus-error logic of a network controller and holds them in a 16-bit pending word. A 16-bit enable word chooses which pending sources may drive the single active-low interrupt line. Pending bits are recorded whatever the enable word says, so software can always see every source that fired.

Software reaches the block through a simple strobe port with four word addresses: 0 pending status (read clears it, write ignored), 1 enable mask (read/write), 2 timer compare (read/write; a write also restarts the timer), 3 timer count (read; a write restarts the timer). A free-running timer counts every cycle and raises the timeout source when its count equals a non-zero compare value. A cable-length change is recorded only while the receiver is enabled.

Top module: `intr_ctrl`

## Requirements
- R1: Status and mask bits 12 down to 7 always read as 0; a mask write keeps only bits 15:13 and 6:0 (0xFFFF reads back as 0xE07F).
- R2: Each event pulse sets its own status bit one clock edge after it is sampled: rx OK bit 0, rx error bit 1, tx OK bit 2, tx error bit 3, rx buffer overflow bit 4, underrun/link change bit 5, rx FIFO overflow bit 6, cable length change bit 13, timeout bit 14, system error bit 15.
- R3: A status bit stays set until a status read, even while its mask bit is 0.
- R4: `irq_n` is 0 exactly when some status bit and its mask bit are both 1; it changes on the same clock edge as the status and mask it depends on, and is 1 after reset.
- R5: A read at address 0 returns the status word on `host_rdata` after the next clock edge and clears every pending bit on that edge.
- R6: An event sampled in the same cycle as a status read is not in the returned word but is pending after the clear.
- R7: A write at address 0 leaves the status word unchanged.
- R8: A write at address 2 loads the compare value C and sets the count to 0; with C non-zero the timeout bit sets on the (C+1)-th clock edge after the write edge.
- R9: With a compare value of 0 the timeout bit never sets.
- R10: A cable-length change pulse sets bit 13 only while `rx_enabled` is 1.
- R11: After reset status, mask, compare value and count are all 0.
- R12: Reads at addresses 1, 2 and 3 return mask, compare value and the current count after the next edge; a write at address 3 sets the count to 0; `host_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_ok | input | 1 | Receive OK pulse |
| ev_rx_err | input | 1 | Receive error pulse |
| ev_tx_ok | input | 1 | Transmit OK pulse |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_rxbuf_ovf | input | 1 | Receive buffer overflow pulse |
| ev_undr_link | input | 1 | Packet underrun or link change pulse |
| ev_fifo_ovf | input | 1 | Receive FIFO overflow pulse |
| ev_len_chg | input | 1 | Cable length change pulse |
| ev_sys_err | input | 1 | System bus error pulse |
| rx_enabled | input | 1 | Receiver enabled level |
| host_req | input | 1 | Host access strobe, one cycle |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | 2 | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Status, mask, count and `irq_n` all move on the clock edge that samples the event or host strobe, and read data lands in `host_rdata` on that same edge, so every result is due one edge after its stimulus. The bench drives inputs at the falling edge, and a reference model updates on the rising edge from the values driven before it; every check is made at the following falling edge. Timer cases count edges from the compare write: the timeout must be absent after C edges and present after C+1.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int STAT_W = 16;

    localparam int B_RX_OK     = 0;
    localparam int B_RX_ERR    = 1;
    localparam int B_TX_OK     = 2;
    localparam int B_TX_ERR    = 3;
    localparam int B_RXBUF_OVF = 4;
    localparam int B_UNDR_LINK = 5;
    localparam int B_FIFO_OVF  = 6;
    localparam int B_LEN_CHG   = 13;
    localparam int B_TIMEOUT   = 14;
    localparam int B_SYS_ERR   = 15;

    // implemented bit positions; 12..7 are reserved
    localparam logic [STAT_W-1:0] IMPL_BITS = 16'hE07F;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_CMP    = 2'd2,
        REG_CNT    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] mask;
        logic              irq_n;
    } stat_regs_t;

endpackage

// File: rtl/intr_timer.sv
module intr_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cmp_we_i,
    input  logic [TMR_W-1:0] cmp_wdata_i,
    output logic [TMR_W-1:0] cnt_o,
    output logic [TMR_W-1:0] cmp_o,
    output logic             match_o
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] cmp;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.cnt = tmr_q.cnt + TMR_W'(1);
        if (clr_i || cmp_we_i) begin
            tmr_d.cnt = '0;
        end
        if (cmp_we_i) begin
            tmr_d.cmp = cmp_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt_o   = tmr_q.cnt;
    assign cmp_o   = tmr_q.cmp;
    assign match_o = (tmr_q.cmp != '0) && (tmr_q.cnt == tmr_q.cmp);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || cmp_we_i) |=> (cnt_o == '0)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i || cmp_we_i) |=> (cnt_o == $past(cnt_o) + TMR_W'(1))); // R12
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_we_i |=> $stable(cmp_o)); // R8

endmodule

// File: rtl/intr_status.sv
module intr_status
    import intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_i,
    input  logic              clr_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_n_o
);

    stat_regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (clr_i ? '0 : st_q.stat) | (ev_i & IMPL_BITS);
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i & IMPL_BITS;
        end
        st_d.irq_n = ~|(st_d.stat & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stat: '0, mask: '0, irq_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.stat;
    assign mask_o   = st_q.mask;
    assign irq_n_o  = st_q.irq_n;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o | mask_o) & ~IMPL_BITS) == '0); // R1
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R3
    AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (status_o == ($past(ev_i) & IMPL_BITS))); // R6
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !(|(status_o & mask_o))); // R4

endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
    import intr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_ok,
    input  logic              ev_rx_err,
    input  logic              ev_tx_ok,
    input  logic              ev_tx_err,
    input  logic              ev_rxbuf_ovf,
    input  logic              ev_undr_link,
    input  logic              ev_fifo_ovf,
    input  logic              ev_len_chg,
    input  logic              ev_sys_err,
    input  logic              rx_enabled,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_n
);

    reg_sel_e          sel;
    logic              rd_stb, wr_stb;
    logic              stat_clr, mask_we, cmp_we, cnt_clr;
    logic              tmo_hit;
    logic [STAT_W-1:0] ev_vec, stat_w, mask_w;
    logic [TMR_W-1:0]  cnt_w, cmp_w;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign sel    = reg_sel_e'(host_addr);
    assign rd_stb = host_req && !host_we;
    assign wr_stb = host_req && host_we;

    assign stat_clr = rd_stb && (sel == REG_STATUS);
    assign mask_we  = wr_stb && (sel == REG_MASK);
    assign cmp_we   = wr_stb && (sel == REG_CMP);
    assign cnt_clr  = wr_stb && (sel == REG_CNT);

    always_comb begin
        ev_vec              = '0;
        ev_vec[B_RX_OK]     = ev_rx_ok;
        ev_vec[B_RX_ERR]    = ev_rx_err;
        ev_vec[B_TX_OK]     = ev_tx_ok;
        ev_vec[B_TX_ERR]    = ev_tx_err;
        ev_vec[B_RXBUF_OVF] = ev_rxbuf_ovf;
        ev_vec[B_UNDR_LINK] = ev_undr_link;
        ev_vec[B_FIFO_OVF]  = ev_fifo_ovf;
        ev_vec[B_LEN_CHG]   = ev_len_chg && rx_enabled;
        ev_vec[B_TIMEOUT]   = tmo_hit;
        ev_vec[B_SYS_ERR]   = ev_sys_err;
    end

    intr_timer #(.TMR_W(TMR_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cnt_clr),
        .cmp_we_i    (cmp_we),
        .cmp_wdata_i (host_wdata[TMR_W-1:0]),
        .cnt_o       (cnt_w),
        .cmp_o       (cmp_w),
        .match_o     (tmo_hit)
    );

    intr_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev_vec),
        .clr_i        (stat_clr),
        .mask_we_i    (mask_we),
        .mask_wdata_i (host_wdata[STAT_W-1:0]),
        .status_o     (stat_w),
        .mask_o       (mask_w),
        .irq_n_o      (irq_n)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_stb) begin
            unique case (sel)
                REG_STATUS: rdata_d = DATA_W'(stat_w);
                REG_MASK:   rdata_d = DATA_W'(mask_w);
                REG_CMP:    rdata_d = DATA_W'(cmp_w);
                REG_CNT:    rdata_d = DATA_W'(cnt_w);
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign host_rdata = rdata_q;

    AST_STATUS_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == REG_STATUS) |=> (stat_w == ($past(stat_w) | ($past(ev_vec) & IMPL_BITS)))); // R7
    AST_LEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enabled && !stat_w[B_LEN_CHG]) |=> !stat_w[B_LEN_CHG]); // R10
    AST_NO_TMO_CMP0: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_w == '0 && !stat_w[B_TIMEOUT]) |=> !stat_w[B_TIMEOUT]); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(host_rdata)); // R12

endmodule

// File: tb/intr_ctrl_test.sv
`timescale 1ns/1ps
module intr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  evs = '0;
    logic        rx_en = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_n;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    logic [15:0] m_stat = '0, m_mask = '0, m_cmp = '0, m_cnt = '0, m_rdata = '0;

    always #2.5 clk = ~clk;

    intr_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_ok(evs[0]), .ev_rx_err(evs[1]), .ev_tx_ok(evs[2]), .ev_tx_err(evs[3]),
        .ev_rxbuf_ovf(evs[4]), .ev_undr_link(evs[5]), .ev_fifo_ovf(evs[6]),
        .ev_len_chg(evs[7]), .ev_sys_err(evs[8]), .rx_enabled(rx_en),
        .host_req(req), .host_we(we), .host_addr(addr), .host_wdata(wdata),
        .host_rdata(rdata), .irq_n(irq_n)
    );

    function automatic logic [15:0] ev_pos(logic [8:0] e, logic rxe, logic tmo);
        return {e[8], tmo, e[7] & rxe, 6'b0, e[6:0]};
    endfunction

    task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: model updates on posedge from pre-edge values, checks at negedge
    task automatic tick(string tag);
        logic        tmo, rd, wr;
        logic [15:0] nstat;
        @(posedge clk);
        tmo = (m_cmp != 0) && (m_cnt == m_cmp);
        rd  = req && !we;
        wr  = req && we;
        if (rd) begin
            case (addr)
                2'd0: m_rdata = m_stat;
                2'd1: m_rdata = m_mask;
                2'd2: m_rdata = m_cmp;
                default: m_rdata = m_cnt;
            endcase
        end
        nstat = ((rd && addr == 2'd0) ? 16'h0 : m_stat) | ev_pos(evs, rx_en, tmo);
        m_stat = nstat;
        if (wr && addr == 2'd1) m_mask = wdata & 16'hE07F;
        if (wr && addr == 2'd2) m_cmp = wdata;
        m_cnt = (wr && (addr == 2'd2 || addr == 2'd3)) ? 16'h0 : m_cnt + 16'd1;
        @(negedge clk);
        chk({15'b0, irq_n}, {15'b0, ~|(m_stat & m_mask)}, (tag == "") ? "R4" : tag);
        if (rd) chk(rdata, m_rdata, (tag == "") ? ((addr == 2'd0) ? "R5" : "R12") : tag);
        evs = '0; req = 1'b0; we = 1'b0;
    endtask

    task automatic host(logic w, logic [1:0] a, logic [15:0] d, string tag);
        req = 1'b1; we = w; addr = a; wdata = d;
        tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk({15'b0, irq_n}, 16'h1, "R11 irq_n in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        host(1'b0, 2'd0, 16'h0, "R11"); chk(rdata, 16'h0, "R11 status");
        host(1'b0, 2'd1, 16'h0, "R11"); chk(rdata, 16'h0, "R11 mask");
        host(1'b0, 2'd2, 16'h0, "R11"); chk(rdata, 16'h0, "R11 cmp");
        // R1 reserved bits
        host(1'b1, 2'd1, 16'hFFFF, "R4");
        host(1'b0, 2'd1, 16'h0, "R1"); chk(rdata, 16'hE07F, "R1 mask readback");
        host(1'b1, 2'd1, 16'h0, "R4");
        // R2 each source lands on its bit
        rx_en = 1'b1;
        for (int i = 0; i < 9; i++) begin
            logic [15:0] pos;
            evs = 9'(1) << i;
            pos = ev_pos(evs, 1'b1, 1'b0);
            tick("R4");
            host(1'b0, 2'd0, 16'h0, "R2"); chk(rdata, pos, "R2 bit position");
        end
        // R3 sticky while masked off
        evs[0] = 1'b1; tick("R3");
        repeat (3) tick("R3");
        chk({15'b0, irq_n}, 16'h1, "R3 masked irq_n");
        host(1'b1, 2'd1, 16'h0001, "R4");
        chk({15'b0, irq_n}, 16'h0, "R4 irq after unmask");
        host(1'b0, 2'd0, 16'h0, "R3"); chk(rdata, 16'h0001, "R3 held bit");
        chk({15'b0, irq_n}, 16'h1, "R5 irq clears on read");
        // R6 event during read
        evs[2] = 1'b1; evs[0] = 1'b1;
        host(1'b0, 2'd0, 16'h0, "R6"); chk(rdata, 16'h0, "R6 read excludes new");
        chk({15'b0, irq_n}, 16'h0, "R6 irq from kept event");
        host(1'b0, 2'd0, 16'h0, "R6"); chk(rdata, 16'h0005, "R6 kept after clear");
        // R7 write to status ignored
        evs[3] = 1'b1; tick("R7");
        host(1'b1, 2'd0, 16'hFFFF, "R7");
        host(1'b1, 2'd0, 16'h0000, "R7");
        host(1'b0, 2'd0, 16'h0, "R7"); chk(rdata, 16'h0008, "R7 status unchanged");
        // R10 cable length gating
        rx_en = 1'b0; evs[7] = 1'b1; tick("R10");
        host(1'b0, 2'd0, 16'h0, "R10"); chk(rdata, 16'h0, "R10 gated off");
        rx_en = 1'b1; evs[7] = 1'b1; tick("R10");
        host(1'b0, 2'd0, 16'h0, "R10"); chk(rdata, 16'h2000, "R10 recorded");
        // R8 timer compare
        host(1'b1, 2'd1, 16'h4000, "R4");
        host(1'b1, 2'd2, 16'd5, "R8");
        repeat (5) tick("R8");
        chk({15'b0, irq_n}, 16'h1, "R8 not yet at C edges");
        tick("R8");
        chk({15'b0, irq_n}, 16'h0, "R8 timeout at C+1 edges");
        host(1'b0, 2'd0, 16'h0, "R8"); chk(rdata, 16'h4000, "R8 timeout bit");
        // R12 count restart and readback
        host(1'b1, 2'd3, 16'h0, "R12");
        repeat (2) tick("R12");
        host(1'b0, 2'd3, 16'h0, "R12"); chk(rdata, 16'd2, "R12 count");
        // R9 compare zero
        host(1'b1, 2'd2, 16'd0, "R9");
        repeat (40) tick("R9");
        chk({15'b0, irq_n}, 16'h1, "R9 no timeout");
        // random phase
        for (int c = 0; c < 4000; c++) begin
            int op;
            evs = 9'($urandom) & 9'($urandom) & 9'($urandom);
            rx_en = 1'($urandom);
            op = int'($urandom % 100);
            if (op < 30) begin
                req = 1'b1; we = 1'b0; addr = 2'($urandom);
            end else if (op < 45) begin
                req = 1'b1; we = 1'b1; addr = 2'($urandom);
                wdata = (addr == 2'd2) ? 16'($urandom % 40) : 16'($urandom);
            end
            tick("");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule